// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns an asynchronous serial line into parallel characters. It counts oversampling ticks from a receive-clock enable. The rate factor can be 1, 16 or 64 ticks per bit. A falling edge on the line marks a possible start bit. In the 16x and 64x modes the line is checked again half a bit later. A short low glitch is therefore dropped, and no character is produced from it. Each data bit is sampled at its centre, least significant bit first. A parity bit and one stop bit may follow the data bits.

A finished character goes into one holding register. A ready flag tells the host that a character is waiting, and a read strobe clears that flag. There is no second buffer. A character that arrives before the previous one is read replaces it and raises the overrun flag. The parity, framing and overrun flags stay set until the host pulses the error-clear input. A separate break flag reports a line held low for two full character times. The `rxd` input is assumed to be synchronous to `clk` already.

Top module: `async_rx_core`

## Requirements
- R1: `rate_sel` picks the ticks per bit (0 = 1, 1 = 16, 2 or 3 = 64). A tick is a rising edge of `clk` with `samp_en` high. Bit k of a frame (the start bit is k = 0) is sampled N·k + N/2 ticks after the first tick that sees the line low. Data arrives least significant bit first. In 1x mode bit k is sampled on tick k.
- R2: In 16x and 64x modes, a low level that is high again at the start-bit centre (N/2 ticks after the edge) loads no character. The receiver then waits for the next falling edge.
- R3: `char_len` 0..3 selects 5..8 data bits. Data bit i appears on `rx_data[i]`. Unused upper bits read as zero, and the parity bit never appears in `rx_data`.
- R4: When `par_en` is 1, one parity bit follows the data. With `par_odd` = 0 the data bits plus the parity bit must hold an even number of ones; with `par_odd` = 1 an odd number. A mismatch sets `par_err`.
- R5: Only the first stop position is sampled. If it is low, `frm_err` is set and the character is still loaded.
- R6: One clock after the stop-sample tick, `rx_data` holds the new character and `rx_rdy` is 1.
- R7: A `rd_stb` pulse clears `rx_rdy` on the next clock and leaves `rx_data` unchanged.
- R8: A load while `rx_rdy` is 1 and `rd_stb` is low replaces `rx_data` and sets `ovr_err`.
- R9: A load in the same clock as `rd_stb` leaves `rx_rdy` at 1 and does not set `ovr_err`.
- R10: `brk_det` rises after the line has been low on 2·(2 + data bits + parity bit)·N consecutive ticks. It clears on the first tick that sees the line high, or on reset. `err_clr` has no effect on it.
- R11: `par_err`, `frm_err` and `ovr_err` stay set through reads and later characters until `err_clr` is pulsed.
- R12: After reset `rx_rdy`, all flags and `rx_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| samp_en | input | 1 | Receive-clock tick enable |
| rxd | input | 1 | Serial line, idle high |
| rate_sel | input | 2 | Ticks per bit: 0=1, 1=16, 2/3=64 |
| char_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rd_stb | input | 1 | Host read of the holding register |
| err_clr | input | 1 | Clear parity, framing and overrun flags |
| rx_data | output | 8 | Holding register |
| rx_rdy | output | 1 | Character waiting |
| par_err | output | 1 | Sticky parity error |
| frm_err | output | 1 | Sticky framing error |
| ovr_err | output | 1 | Sticky overrun |
| brk_det | output | 1 | Line held low for two character times |

## Verification
A character load and a host read can land on the same clock edge. The bench provokes this by timing `rd_stb` to the exact tick of the stop-bit sample of a second character, while the first character is still unread. It then checks that `rx_rdy` stays high, `ovr_err` stays low and `rx_data` holds the second character. The same load edge is also tested without the read, where the overrun flag must rise.

// File: rtl/rx_pkg.sv
package rx_pkg;
    localparam int OVS_MID = 16;
    localparam int OVS_HI  = 64;
    localparam int PH_W    = $clog2(OVS_HI);
    localparam int NT_W    = PH_W + 1;
    localparam int DATA_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_char_t;

    function automatic logic [NT_W-1:0] ovs_of(input logic [1:0] sel);
        case (sel)
            2'd0:    ovs_of = NT_W'(1);
            2'd1:    ovs_of = NT_W'(OVS_MID);
            default: ovs_of = NT_W'(OVS_HI);
        endcase
    endfunction
endpackage

// File: rtl/rx_frame.sv
module rx_frame
    import rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     samp_en,
    input  logic     rxd,
    input  logic [1:0] rate_sel,
    input  logic [1:0] char_len,
    input  logic     par_en,
    input  logic     par_odd,
    output logic     done_o,
    output rx_char_t ch_o
);
    typedef struct packed {
        rx_state_e         st;
        logic [PH_W-1:0]   ph;
        logic [2:0]        idx;
        logic [DATA_W-1:0] sh;
        logic              acc;
        logic              pbit;
        logic              prev;
    } fr_t;

    fr_t q, n;
    logic [NT_W-1:0] nt, last_ph, half_m1;
    logic            at_last, at_half;

    always_comb begin
        n       = q;
        done_o  = 1'b0;
        ch_o    = '0;
        nt      = ovs_of(rate_sel);
        last_ph = nt - 1'b1;
        half_m1 = (nt >> 1) - 1'b1;
        at_last = ({1'b0, q.ph} == last_ph);
        at_half = ({1'b0, q.ph} == half_m1);
        if (samp_en) begin
            n.prev = rxd;
            unique case (q.st)
                ST_IDLE: begin
                    if (q.prev && !rxd) begin
                        n.ph  = '0;
                        n.idx = '0;
                        n.acc = 1'b0;
                        n.st  = (nt == NT_W'(1)) ? ST_DATA : ST_START;
                    end
                end
                ST_START: begin
                    if (at_half) begin
                        n.ph = '0;
                        n.st = rxd ? ST_IDLE : ST_DATA;
                    end else begin
                        n.ph = q.ph + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (at_last) begin
                        n.ph  = '0;
                        n.sh  = {rxd, q.sh[DATA_W-1:1]};
                        n.acc = q.acc ^ rxd;
                        n.idx = q.idx + 1'b1;
                        if (q.idx == {1'b1, char_len})
                            n.st = par_en ? ST_PAR : ST_STOP;
                    end else begin
                        n.ph = q.ph + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (at_last) begin
                        n.ph   = '0;
                        n.pbit = rxd;
                        n.st   = ST_STOP;
                    end else begin
                        n.ph = q.ph + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (at_last) begin
                        n.ph      = '0;
                        n.st      = ST_IDLE;
                        done_o    = 1'b1;
                        ch_o.data = q.sh >> (2'd3 - char_len);
                        ch_o.perr = par_en && ((q.acc ^ q.pbit) != par_odd);
                        ch_o.ferr = !rxd;
                    end else begin
                        n.ph = q.ph + 1'b1;
                    end
                end
                default: n.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ph: '0, idx: '0, sh: '0, acc: 1'b0, pbit: 1'b0, prev: 1'b1};
        end else begin
            q <= n;
        end
    end

    // R1: a character completes only on a sampling tick
    p_done_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> samp_en);
endmodule

// File: rtl/rx_brk.sv
module rx_brk
    import rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       samp_en,
    input  logic       rxd,
    input  logic [1:0] rate_sel,
    input  logic [1:0] char_len,
    input  logic       par_en,
    output logic       brk_o
);
    localparam int MAX_BITS = 2 + DATA_W + 1;
    localparam int CNT_W    = $clog2(2 * MAX_BITS * OVS_HI + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             brk;
    } bk_t;

    bk_t q, n;
    logic [CNT_W-1:0] bits_w, nt_w, limit, cnt_inc;

    always_comb begin
        n       = q;
        bits_w  = CNT_W'(7) + CNT_W'(char_len) + CNT_W'(par_en);
        nt_w    = CNT_W'(ovs_of(rate_sel));
        limit   = (bits_w * nt_w) << 1;
        cnt_inc = q.cnt + 1'b1;
        if (samp_en) begin
            if (rxd) begin
                n.cnt = '0;
                n.brk = 1'b0;
            end else begin
                if (q.cnt < limit) n.cnt = cnt_inc;
                if (cnt_inc >= limit) n.brk = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign brk_o = q.brk;

    // R10: a high line on a tick ends the break indication
    p_brk_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_en && rxd) |=> !brk_o);
endmodule

// File: rtl/rx_hold.sv
module rx_hold
    import rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  rx_char_t          ch,
    input  logic              rd_stb,
    input  logic              err_clr,
    output logic [DATA_W-1:0] data_o,
    output logic              rdy_o,
    output logic              perr_o,
    output logic              ferr_o,
    output logic              ovr_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              rdy;
        logic              perr;
        logic              ferr;
        logic              ovr;
    } hd_t;

    hd_t q, n;

    always_comb begin
        n = q;
        if (rd_stb) n.rdy = 1'b0;
        if (err_clr) begin
            n.perr = 1'b0;
            n.ferr = 1'b0;
            n.ovr  = 1'b0;
        end
        if (load) begin
            n.data = ch.data;
            n.rdy  = 1'b1;
            if (q.rdy && !rd_stb) n.ovr  = 1'b1;
            if (ch.perr)          n.perr = 1'b1;
            if (ch.ferr)          n.ferr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign data_o = q.data;
    assign rdy_o  = q.rdy;
    assign perr_o = q.perr;
    assign ferr_o = q.ferr;
    assign ovr_o  = q.ovr;

    // R6
    p_load_sets_rdy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> rdy_o);
    // R7
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !load) |=> !rdy_o);
    // R8
    p_ovr_on_unread_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && rdy_o && !rd_stb) |=> ovr_o);
    // R9
    p_no_ovr_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && rd_stb && !ovr_o) |=> !ovr_o);
    // R11
    p_perr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_o && !err_clr) |=> perr_o);
endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
    import rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       samp_en,
    input  logic       rxd,
    input  logic [1:0] rate_sel,
    input  logic [1:0] char_len,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rd_stb,
    input  logic       err_clr,
    output logic [7:0] rx_data,
    output logic       rx_rdy,
    output logic       par_err,
    output logic       frm_err,
    output logic       ovr_err,
    output logic       brk_det
);
    logic     done;
    rx_char_t ch;

    rx_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp_en  (samp_en),
        .rxd      (rxd),
        .rate_sel (rate_sel),
        .char_len (char_len),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .done_o   (done),
        .ch_o     (ch)
    );

    rx_brk u_brk (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp_en  (samp_en),
        .rxd      (rxd),
        .rate_sel (rate_sel),
        .char_len (char_len),
        .par_en   (par_en),
        .brk_o    (brk_det)
    );

    rx_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (done),
        .ch      (ch),
        .rd_stb  (rd_stb),
        .err_clr (err_clr),
        .data_o  (rx_data),
        .rdy_o   (rx_rdy),
        .perr_o  (par_err),
        .ferr_o  (frm_err),
        .ovr_o   (ovr_err)
    );
endmodule

// File: tb/tb_async_rx_core.sv
module tb_async_rx_core;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       samp_en = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] rate_sel = 2'd1;
    logic [1:0] char_len = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd_stb = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_rdy, par_err, frm_err, ovr_err, brk_det;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  sb_on = 1'b0;
    bit  gate = 1'b0;
    bit  fin = 1'b0;

    typedef struct {
        logic [7:0] d;
        logic       pe;
        logic       fe;
    } exp_t;
    exp_t exp_q[$];

    async_rx_core dut (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rxd(rxd),
        .rate_sel(rate_sel), .char_len(char_len), .par_en(par_en),
        .par_odd(par_odd), .rd_stb(rd_stb), .err_clr(err_clr),
        .rx_data(rx_data), .rx_rdy(rx_rdy), .par_err(par_err),
        .frm_err(frm_err), .ovr_err(ovr_err), .brk_det(brk_det)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            samp_en <= gate ? ~samp_en : 1'b1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int ticks_per_bit();
        return (rate_sel == 2'd0) ? 1 : (rate_sel == 2'd1) ? 16 : 64;
    endfunction

    task automatic tick_wait(input int n);
        int c = 0;
        if (n <= 0) return;
        while (c < n) begin
            @(posedge clk);
            if (samp_en) c++;
        end
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop, input bit collide);
        int         n   = ticks_per_bit();
        int         len = 5 + int'(char_len);
        logic [7:0] m   = 8'hFF >> (8 - len);
        exp_t       e;
        rxd = 1'b0;
        tick_wait(n);
        for (int i = 0; i < len; i++) begin
            rxd = d[i];
            tick_wait(n);
        end
        if (par_en) begin
            rxd = (^(d & m)) ^ par_odd ^ bad_par;
            tick_wait(n);
        end
        if (sb_on) begin
            e.d  = d & m;
            e.pe = par_en & bad_par;
            e.fe = bad_stop;
            exp_q.push_back(e);
        end
        rxd = !bad_stop;
        if (collide) begin
            tick_wait(n / 2);
            rd_stb = 1'b1;
            tick_wait(1);
            rd_stb = 1'b0;
            tick_wait(n - n / 2 - 1);
        end else begin
            tick_wait(n);
        end
        rxd = 1'b1;
        if (bad_stop) tick_wait(n);
    endtask

    task automatic pulse_rd();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    // Monitor: pop the expected character on each ready, then read and clear
    initial begin
        bit   pend = 1'b0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (pend) begin
                rd_stb  = 1'b0;
                err_clr = 1'b0;
                pend    = 1'b0;
                chk("R7 ready after read", 32'(rx_rdy), 32'd0);
            end else if (sb_on && rx_rdy) begin
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected character", 32'(rx_data), 32'hFFFF);
                end else begin
                    e = exp_q.pop_front();
                    chk("R1/R3 data", 32'(rx_data), 32'(e.d));
                    chk("R4 parity flag", 32'(par_err), 32'(e.pe));
                    chk("R5 framing flag", 32'(frm_err), 32'(e.fe));
                end
                rd_stb  = 1'b1;
                err_clr = 1'b1;
                pend    = 1'b1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12
        chk("R12 ready", 32'(rx_rdy), 32'd0);
        chk("R12 data", 32'(rx_data), 32'd0);
        chk("R12 flags", 32'({par_err, frm_err, ovr_err, brk_det}), 32'd0);

        sb_on = 1'b1;
        // R1 16x, 8 bits
        rate_sel = 2'd1; char_len = 2'd3;
        send(8'hA5, 0, 0, 0);
        send(8'h3C, 0, 0, 0);
        // R3 shorter characters
        char_len = 2'd0; send(8'hFF, 0, 0, 0);
        char_len = 2'd1; send(8'hC7, 0, 0, 0);
        char_len = 2'd2; send(8'h80, 0, 0, 0);
        // R4 parity even/odd, good and bad
        char_len = 2'd3; par_en = 1'b1;
        par_odd = 1'b0; send(8'h5A, 0, 0, 0);
        par_odd = 1'b1; send(8'h13, 0, 0, 0);
        par_odd = 1'b0; send(8'h6E, 1, 0, 0);
        par_odd = 1'b1; send(8'h01, 1, 0, 0);
        par_en = 1'b0;
        // R5 missing stop bit
        send(8'h55, 0, 1, 0);
        // R1 1x mode with odd parity
        rate_sel = 2'd0; par_en = 1'b1; par_odd = 1'b1;
        send(8'h96, 0, 0, 0);
        send(8'h0F, 1, 0, 0);
        par_en = 1'b0;
        // R1 64x mode
        rate_sel = 2'd2;
        send(8'h61, 0, 0, 0);
        // R1 gated tick enable
        rate_sel = 2'd1; gate = 1'b1;
        send(8'hC3, 0, 0, 0);
        gate = 1'b0;
        tick_wait(4);
        // R2 glitch shorter than half a bit
        rxd = 1'b0; tick_wait(4);
        rxd = 1'b1; tick_wait(40);
        chk("R2 glitch loads nothing", 32'(rx_rdy), 32'd0);
        send(8'h77, 0, 0, 0);
        tick_wait(20);
        chk("R1 all characters seen", 32'(exp_q.size()), 32'd0);
        sb_on = 1'b0;
        tick_wait(4);

        // R8 overrun
        send(8'h11, 0, 0, 0);
        chk("R6 ready after load", 32'(rx_rdy), 32'd1);
        chk("R6 data after load", 32'(rx_data), 32'h11);
        send(8'h22, 0, 0, 0);
        chk("R8 overrun flag", 32'(ovr_err), 32'd1);
        chk("R8 data replaced", 32'(rx_data), 32'h22);
        pulse_rd();
        chk("R7 ready cleared", 32'(rx_rdy), 32'd0);
        chk("R7 data kept", 32'(rx_data), 32'h22);
        chk("R11 overrun sticky", 32'(ovr_err), 32'd1);
        pulse_clr();
        chk("R11 overrun cleared", 32'(ovr_err), 32'd0);

        // R9 load and read in the same clock
        send(8'h44, 0, 0, 0);
        send(8'h55, 0, 0, 1);
        chk("R9 ready stays", 32'(rx_rdy), 32'd1);
        chk("R9 no overrun", 32'(ovr_err), 32'd0);
        chk("R9 data", 32'(rx_data), 32'h55);
        pulse_rd();

        // R10 break: 8 data bits, no parity, 16x -> 320 ticks
        rxd = 1'b0;
        tick_wait(319);
        chk("R10 no break yet", 32'(brk_det), 32'd0);
        tick_wait(1);
        chk("R10 break set", 32'(brk_det), 32'd1);
        chk("R5 break frame framing", 32'(frm_err), 32'd1);
        chk("R5 break frame data", 32'(rx_data), 32'h00);
        pulse_clr();
        chk("R10 break ignores clear", 32'(brk_det), 32'd1);
        chk("R11 framing cleared", 32'(frm_err), 32'd0);
        rxd = 1'b1;
        tick_wait(1);
        chk("R10 break cleared", 32'(brk_det), 32'd0);
        pulse_rd();

        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule